// File: doc/BRIEF.md
# Interlace-Aware Beam Timing Generator

This block produces the horizontal and vertical beam position of a raster video system whose master clock runs four cycles per dot. One clock is one master cycle. The block keeps an even/odd field bit and changes the length of a frame with the interlace mode. In progressive mode it shortens one line by a dot on odd fields. Around the raster it marks the start of vertical blank and keeps a blank status flag that is cleared when read. It raises an NMI request a fixed number of cycles into the blanking line, and it gives the master-cycle slot and busy window of the per-line memory refresh.

Interlace changes take effect only at a frame boundary, so a frame never changes length while it runs. The overscan select chooses the later blanking line. The revision select chooses between a fixed refresh slot and one that alternates from line to line. All counts are parameters, so a bench can shrink the raster while every relation between the counts stays the same.

Top module: `beam_timing_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to horizontal 0, line 0, field 0, progressive mode, with `vblank_start_o`, `status_o` and `nmi_req_o` low and the refresh slot at REFRESH_POS.
- R2: The horizontal count steps by one each cycle. After its last value (LINE_DOTS*DOT_CYC-1 on a normal line, 1363 by default) it returns to 0, and the line count advances in that same cycle.
- R3: The line count runs from 0 to the frame line count minus one. After the last line it returns to 0 and `field_o` inverts.
- R4: A frame has FRAME_LINES lines (262). It has one more line when interlace is latched on and the new field is 0. `interlace_en` is sampled only at the frame wrap, so a change applies from the next frame.
- R5: In progressive mode, line SHORT_LINE (240) of a field-1 frame is one dot (DOT_CYC cycles) shorter. All other lines, and every line in interlace mode, keep the full length.
- R6: `vblank_start_o` is high for exactly one cycle, at horizontal 0 of line VBL_LINE (225), or of line VBL_LINE_OS (240) when `overscan_sel` is 1. In the same cycle `status_o` goes high.
- R7: If `nmi_en` is 1 when blank starts, `nmi_req_o` rises when the horizontal count reaches NMI_DELAY (12) on the blanking line. It stays high until the frame wrap. With `nmi_en` at 0 it stays low.
- R8: A `status_rd` pulse clears `status_o` one cycle later. A frame wrap also clears it. When a read and the blank start fall on the same cycle, the flag is set.
- R9: With `rev2_sel` = 0 the refresh slot is REFRESH_POS (538) on every line. `refresh_busy_o` is high for horizontal counts from the slot up to slot+REFRESH_LEN-1 (40 cycles).
- R10: With `rev2_sel` = 1 the slot alternates between REFRESH_POS and REFRESH_POS-DOT_CYC (534) from one line to the next. The slot does not change when the next line is the shortened line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one cycle per master tick |
| rst_n | input | 1 | Synchronous active-low reset |
| interlace_en | input | 1 | Interlace mode request, applied at frame wrap |
| overscan_sel | input | 1 | 1 selects the later blanking line |
| nmi_en | input | 1 | Enables the NMI request at blank start |
| rev2_sel | input | 1 | 1 selects the alternating refresh slot |
| status_rd | input | 1 | One-cycle strobe: the status flag is being read |
| hcount_o | output | HC_W | Horizontal position in master cycles |
| vcount_o | output | VC_W | Line number within the frame |
| field_o | output | 1 | Current field, 0 even, 1 odd |
| vblank_start_o | output | 1 | One-cycle pulse at the first cycle of blank |
| status_o | output | 1 | Blank status flag, cleared on read or at frame wrap |
| nmi_req_o | output | 1 | NMI request level |
| refresh_slot_o | output | HC_W | Horizontal count at which refresh begins on this line |
| refresh_busy_o | output | 1 | High during the refresh window |

## Verification
The bench measures whole frames in cycles, so a frame that ignores the field-dependent extra line or the short line shows up as a cycle total that is off by one line or one dot. It changes interlace in the middle of a frame: a design that applies the change at once gives a wrong length for that frame. It pulses the status read in the same cycle that blank begins, where a design that gives the clear priority would lose the flag. It then watches the refresh slot across the short line, where a design that alternates on every line would show two different slots where equal ones are required.

// File: rtl/beam_pkg.sv
// Shared types for the beam timing generator.
package beam_pkg;

    // Per-cycle step information passed from the line counter to its users.
    typedef struct packed {
        logic line_wrap;   // this cycle is the last of the line
        logic frame_wrap;  // this cycle is the last of the frame
        logic next_short;  // the line that follows is the shortened one
    } beam_step_t;

endpackage

// File: rtl/beam_hcount.sv
// Horizontal counter in master cycles.
// Assumes: short_line is stable for the whole line (it comes from line-rate state).
module beam_hcount #(
    parameter int HC_W     = 11,
    parameter int LINE_CYC = 1364,
    parameter int DOT_CYC  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            short_line,
    output logic [HC_W-1:0] hc,
    output logic            line_wrap
);
    localparam logic [HC_W-1:0] LAST_FULL  = HC_W'(LINE_CYC - 1);
    localparam logic [HC_W-1:0] LAST_SHORT = HC_W'(LINE_CYC - DOT_CYC - 1);

    // Last cycle of the current line, full or one dot short.
    always_comb begin
        line_wrap = (hc == (short_line ? LAST_SHORT : LAST_FULL));
    end

    // Count master cycles and wrap at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n)         hc <= '0;
        else if (line_wrap) hc <= '0;
        else                hc <= hc + 1'b1;
    end
endmodule

// File: rtl/beam_vcount.sv
// Line counter, field bit and frame-length control.
// Assumes: line_wrap is high for one cycle at the end of every line. The
// interlace request is latched only at the frame wrap.
module beam_vcount
    import beam_pkg::*;
#(
    parameter int VC_W        = 9,
    parameter int FRAME_LINES = 262,
    parameter int SHORT_LINE  = 240
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_wrap,
    input  logic            interlace_en,
    output logic [VC_W-1:0] vc,
    output logic [VC_W-1:0] vc_next,
    output logic            field,
    output logic            short_line,
    output beam_step_t      step
);
    localparam logic [VC_W-1:0] LINES_P = VC_W'(FRAME_LINES);
    localparam logic [VC_W-1:0] LINES_I = VC_W'(FRAME_LINES + 1);
    localparam logic [VC_W-1:0] SHORT_V = VC_W'(SHORT_LINE);

    logic            il_q;
    logic [VC_W-1:0] frame_max;
    logic [VC_W-1:0] vc_inc;
    logic            frame_end;

    // Next line number and frame-end detection.
    always_comb begin
        vc_inc     = vc + 1'b1;
        frame_end  = (vc_inc == frame_max);
        vc_next    = frame_end ? '0 : vc_inc;
        short_line = (vc == SHORT_V) && !il_q && field;
        step.line_wrap  = line_wrap;
        step.frame_wrap = line_wrap && frame_end;
        step.next_short = !frame_end && (vc_inc == SHORT_V) && !il_q && field;
    end

    // Advance lines. At frame wrap: toggle field, latch mode, set next length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vc        <= '0;
            field     <= 1'b0;
            il_q      <= 1'b0;
            frame_max <= LINES_P;
        end else if (line_wrap) begin
            vc <= vc_next;
            if (frame_end) begin
                field     <= ~field;
                il_q      <= interlace_en;
                frame_max <= (interlace_en && field) ? LINES_I : LINES_P;
            end
        end
    end
endmodule

// File: rtl/beam_events.sv
// Blank start pulse, clear-on-read status flag and delayed NMI request.
// Assumes: the blanking line is never line 0 and 1 <= NMI_DELAY < line length.
module beam_events
    import beam_pkg::*;
#(
    parameter int HC_W        = 11,
    parameter int VC_W        = 9,
    parameter int VBL_LINE    = 225,
    parameter int VBL_LINE_OS = 240,
    parameter int NMI_DELAY   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  beam_step_t      step,
    input  logic [VC_W-1:0] vc_next,
    input  logic [HC_W-1:0] hc,
    input  logic            overscan_sel,
    input  logic            nmi_en,
    input  logic            status_rd,
    output logic            vblank_start,
    output logic            status,
    output logic            nmi_req
);
    localparam logic [VC_W-1:0] VBL_V    = VC_W'(VBL_LINE);
    localparam logic [VC_W-1:0] VBL_V_OS = VC_W'(VBL_LINE_OS);
    localparam logic [HC_W-1:0] FIRE_HC  = HC_W'(NMI_DELAY - 1);

    logic vbl_hit;
    logic armed;
    logic fire;

    // The line about to begin is the first blanking line.
    always_comb begin
        vbl_hit = step.line_wrap && (vc_next == (overscan_sel ? VBL_V_OS : VBL_V));
        fire    = armed && (hc == FIRE_HC);
    end

    // One-cycle pulse aligned with horizontal 0 of the blanking line.
    always_ff @(posedge clk) begin
        if (!rst_n) vblank_start <= 1'b0;
        else        vblank_start <= vbl_hit;
    end

    // Status flag: wrap clears, blank start sets, a read clears.
    always_ff @(posedge clk) begin
        if (!rst_n)               status <= 1'b0;
        else if (step.frame_wrap) status <= 1'b0;
        else if (vbl_hit)         status <= 1'b1;
        else if (status_rd)       status <= 1'b0;
    end

    // Arm the NMI at blank start when enabled; disarm once it fires.
    always_ff @(posedge clk) begin
        if (!rst_n)               armed <= 1'b0;
        else if (step.frame_wrap) armed <= 1'b0;
        else if (vbl_hit)         armed <= nmi_en;
        else if (fire)            armed <= 1'b0;
    end

    // NMI request level, held until the frame wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)               nmi_req <= 1'b0;
        else if (step.frame_wrap) nmi_req <= 1'b0;
        else if (fire)            nmi_req <= 1'b1;
    end
endmodule

// File: rtl/beam_refresh.sv
// Per-line memory refresh slot and busy window.
// Assumes: slot + REFRESH_LEN fits within the shortest line.
module beam_refresh
    import beam_pkg::*;
#(
    parameter int HC_W        = 11,
    parameter int DOT_CYC     = 4,
    parameter int REFRESH_POS = 538,
    parameter int REFRESH_LEN = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  beam_step_t      step,
    input  logic [HC_W-1:0] hc,
    input  logic            rev2_sel,
    output logic [HC_W-1:0] slot,
    output logic            busy
);
    localparam logic [HC_W-1:0] POS_LATE  = HC_W'(REFRESH_POS);
    localparam logic [HC_W-1:0] POS_EARLY = HC_W'(REFRESH_POS - DOT_CYC);
    localparam logic [HC_W:0]   LEN_W     = (HC_W+1)'(REFRESH_LEN);

    logic          alt;
    logic [HC_W:0] slot_end;

    // Alternate phase flips at each line start except entry to the short line.
    always_ff @(posedge clk) begin
        if (!rst_n)                                alt <= 1'b0;
        else if (step.line_wrap && !step.next_short) alt <= ~alt;
    end

    // Slot choice and busy window.
    always_comb begin
        slot     = (rev2_sel && alt) ? POS_EARLY : POS_LATE;
        slot_end = {1'b0, slot} + LEN_W;
        busy     = (hc >= slot) && ({1'b0, hc} < slot_end);
    end
endmodule

// File: rtl/beam_timing_gen.sv
// Top of the beam timing generator. One clock is one master cycle.
// Assumes: all control inputs are synchronous to clk.
module beam_timing_gen
    import beam_pkg::*;
#(
    parameter int DOT_CYC     = 4,
    parameter int LINE_DOTS   = 341,
    parameter int FRAME_LINES = 262,
    parameter int SHORT_LINE  = 240,
    parameter int VBL_LINE    = 225,
    parameter int VBL_LINE_OS = 240,
    parameter int NMI_DELAY   = 12,
    parameter int REFRESH_POS = 538,
    parameter int REFRESH_LEN = 40,
    localparam int LINE_CYC   = DOT_CYC * LINE_DOTS,
    localparam int HC_W       = $clog2(LINE_CYC),
    localparam int VC_W       = $clog2(FRAME_LINES + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            interlace_en,
    input  logic            overscan_sel,
    input  logic            nmi_en,
    input  logic            rev2_sel,
    input  logic            status_rd,
    output logic [HC_W-1:0] hcount_o,
    output logic [VC_W-1:0] vcount_o,
    output logic            field_o,
    output logic            vblank_start_o,
    output logic            status_o,
    output logic            nmi_req_o,
    output logic [HC_W-1:0] refresh_slot_o,
    output logic            refresh_busy_o
);
    logic            short_line;
    logic            line_wrap;
    logic [VC_W-1:0] vc_next;
    beam_step_t      step;

    beam_hcount #(.HC_W(HC_W), .LINE_CYC(LINE_CYC), .DOT_CYC(DOT_CYC)) u_h (
        .clk(clk), .rst_n(rst_n), .short_line(short_line),
        .hc(hcount_o), .line_wrap(line_wrap)
    );

    beam_vcount #(.VC_W(VC_W), .FRAME_LINES(FRAME_LINES), .SHORT_LINE(SHORT_LINE)) u_v (
        .clk(clk), .rst_n(rst_n), .line_wrap(line_wrap), .interlace_en(interlace_en),
        .vc(vcount_o), .vc_next(vc_next), .field(field_o),
        .short_line(short_line), .step(step)
    );

    beam_events #(.HC_W(HC_W), .VC_W(VC_W), .VBL_LINE(VBL_LINE),
                  .VBL_LINE_OS(VBL_LINE_OS), .NMI_DELAY(NMI_DELAY)) u_ev (
        .clk(clk), .rst_n(rst_n), .step(step), .vc_next(vc_next), .hc(hcount_o),
        .overscan_sel(overscan_sel), .nmi_en(nmi_en), .status_rd(status_rd),
        .vblank_start(vblank_start_o), .status(status_o), .nmi_req(nmi_req_o)
    );

    beam_refresh #(.HC_W(HC_W), .DOT_CYC(DOT_CYC), .REFRESH_POS(REFRESH_POS),
                   .REFRESH_LEN(REFRESH_LEN)) u_rf (
        .clk(clk), .rst_n(rst_n), .step(step), .hc(hcount_o), .rev2_sel(rev2_sel),
        .slot(refresh_slot_o), .busy(refresh_busy_o)
    );
endmodule

// File: rtl/beam_timing_chk.sv
// Assertion checker for beam_timing_gen, attached by bind.
// Assumes: reset is held low from time zero.
module beam_timing_chk #(
    parameter int HC_W      = 11,
    parameter int VC_W      = 9,
    parameter int NMI_DELAY = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic [HC_W-1:0] hcount,
    input logic [VC_W-1:0] vcount,
    input logic            field,
    input logic            vblank_start,
    input logic            status,
    input logic            nmi_req,
    input logic [HC_W-1:0] refresh_slot,
    input logic            refresh_busy
);
    // R2
    hc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount != '0) |-> (hcount == HC_W'($past(hcount) + 1'b1)));

    // R3
    vc_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vcount) |-> (hcount == '0));

    // R3
    field_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field) |-> (vcount == '0 && hcount == '0));

    // R6
    vbl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_start |=> !vblank_start);

    // R6
    vbl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_start |-> (status && hcount == '0));

    // R7
    nmi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> (hcount == HC_W'(NMI_DELAY)));

    // R9
    busy_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_busy |-> (hcount >= refresh_slot));
endmodule

bind beam_timing_gen beam_timing_chk #(.HC_W(HC_W), .VC_W(VC_W), .NMI_DELAY(NMI_DELAY)) u_chk (
    .clk(clk), .rst_n(rst_n), .hcount(hcount_o), .vcount(vcount_o), .field(field_o),
    .vblank_start(vblank_start_o), .status(status_o), .nmi_req(nmi_req_o),
    .refresh_slot(refresh_slot_o), .refresh_busy(refresh_busy_o)
);

// File: tb/sim_beam_timing_gen.sv
// Directed bench for beam_timing_gen on a shrunken raster:
// 12 dots x 4 cycles = 48-cycle lines, 10-line frames, short line 8,
// blank at line 6 (8 with overscan), NMI at 12, refresh slot 22 / 18, 6 cycles.
module sim_beam_timing_gen;
    localparam int HC_W = 6;
    localparam int VC_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic interlace_en = 1'b0, overscan_sel = 1'b0, nmi_en = 1'b0;
    logic rev2_sel = 1'b0, status_rd = 1'b0;
    logic [HC_W-1:0] hcount_o, refresh_slot_o;
    logic [VC_W-1:0] vcount_o;
    logic field_o, vblank_start_o, status_o, nmi_req_o, refresh_busy_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    beam_timing_gen #(
        .DOT_CYC(4), .LINE_DOTS(12), .FRAME_LINES(10), .SHORT_LINE(8),
        .VBL_LINE(6), .VBL_LINE_OS(8), .NMI_DELAY(12),
        .REFRESH_POS(22), .REFRESH_LEN(6)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .interlace_en(interlace_en),
        .overscan_sel(overscan_sel), .nmi_en(nmi_en), .rev2_sel(rev2_sel),
        .status_rd(status_rd), .hcount_o(hcount_o), .vcount_o(vcount_o),
        .field_o(field_o), .vblank_start_o(vblank_start_o), .status_o(status_o),
        .nmi_req_o(nmi_req_o), .refresh_slot_o(refresh_slot_o),
        .refresh_busy_o(refresh_busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_at(input int v, input int h);
        while (!(int'(vcount_o) == v && int'(hcount_o) == h)) @(negedge clk);
    endtask

    // Cycles from the start of line v to the start of the next line.
    task automatic measure_line(input int v, output int n);
        wait_at(v, 0);
        n = 0;
        do begin @(negedge clk); n++; end while (hcount_o != 0);
    endtask

    // Cycles of the frame starting at the next (0,0), with its field.
    task automatic measure_frame(output int n, output int f);
        wait_at(0, 0);
        f = int'(field_o);
        n = 0;
        do begin @(negedge clk); n++; end while (!(vcount_o == 0 && hcount_o == 0));
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        chk(hcount_o == 0 && vcount_o == 0, "R1 position", int'(hcount_o) + int'(vcount_o), 0);
        chk(field_o == 0, "R1 field", int'(field_o), 0);
        chk(!vblank_start_o && !status_o && !nmi_req_o, "R1 flags",
            int'({vblank_start_o, status_o, nmi_req_o}), 0);
        chk(refresh_slot_o == 22, "R1 slot", int'(refresh_slot_o), 22);
        rst_n = 1'b1;
    endtask

    task automatic t_line;
        int n;
        measure_line(1, n);
        chk(n == 48, "R2 line length", n, 48);
        chk(vcount_o == 2, "R2 line advance", int'(vcount_o), 2);
    endtask

    task automatic t_progressive;
        int n, f, n2, f2, ls;
        measure_frame(n, f);
        measure_frame(n2, f2);
        chk(f2 == 1 - f, "R3 field toggle", f2, 1 - f);
        chk(n == ((f == 1) ? 476 : 480), "R5 progressive frame", n, (f == 1) ? 476 : 480);
        chk(n2 == ((f2 == 1) ? 476 : 480), "R5 progressive frame", n2, (f2 == 1) ? 476 : 480);
        // short line only on the odd field
        wait_at(0, 0);
        if (field_o != 1) begin measure_frame(n, f); end
        measure_line(8, ls);
        chk(ls == 44, "R5 short line odd field", ls, 44);
        measure_line(8, ls);
        chk(ls == 48, "R5 full line even field", ls, 48);
    endtask

    task automatic t_interlace;
        int n, f;
        wait_at(0, 0);
        if (field_o != 1) measure_frame(n, f);
        interlace_en = 1'b1;                 // mid-frame request
        measure_frame(n, f);
        chk(n == 476, "R4 change waits for wrap", n, 476);
        measure_frame(n, f);
        chk(f == 0 && n == 528, "R4 interlace even frame", n, 528);
        interlace_en = 1'b0;
        measure_frame(n, f);
        chk(f == 1 && n == 480, "R5 interlace odd frame no short line", n, 480);
        measure_frame(n, f);
        chk(f == 0 && n == 480, "R4 back to progressive", n, 480);
    endtask

    task automatic t_vblank;
        overscan_sel = 1'b0;
        wait_at(5, 47);
        chk(!vblank_start_o && !status_o, "R6 before blank",
            int'({vblank_start_o, status_o}), 0);
        @(negedge clk);
        chk(vblank_start_o && status_o, "R6 blank start line 6",
            int'({vblank_start_o, status_o}), 3);
        @(negedge clk);
        chk(!vblank_start_o, "R6 single cycle pulse", int'(vblank_start_o), 0);
        overscan_sel = 1'b1;
        wait_at(6, 0);
        chk(!vblank_start_o && !status_o, "R6 overscan no early blank",
            int'({vblank_start_o, status_o}), 0);
        wait_at(8, 0);
        chk(vblank_start_o && status_o, "R6 overscan blank line 8",
            int'({vblank_start_o, status_o}), 3);
        overscan_sel = 1'b0;
    endtask

    task automatic t_nmi;
        nmi_en = 1'b1;
        wait_at(6, 11);
        chk(!nmi_req_o, "R7 nmi not early", int'(nmi_req_o), 0);
        @(negedge clk);
        chk(nmi_req_o, "R7 nmi at delay", int'(nmi_req_o), 1);
        wait_at(9, 40);
        chk(nmi_req_o && status_o, "R7 nmi held, R8 flag held",
            int'({nmi_req_o, status_o}), 3);
        nmi_en = 1'b0;
        wait_at(0, 0);
        chk(!nmi_req_o, "R7 nmi cleared at wrap", int'(nmi_req_o), 0);
        chk(!status_o, "R8 status cleared at wrap", int'(status_o), 0);
        wait_at(6, 30);
        chk(!nmi_req_o, "R7 disabled nmi", int'(nmi_req_o), 0);
    endtask

    task automatic t_status;
        wait_at(6, 5);
        chk(status_o, "R8 flag set", int'(status_o), 1);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        chk(!status_o, "R8 cleared by read", int'(status_o), 0);
        wait_at(7, 0);
        chk(!status_o, "R8 stays cleared", int'(status_o), 0);
        wait_at(5, 47);
        status_rd = 1'b1;                    // read on the blank start edge
        @(negedge clk);
        status_rd = 1'b0;
        chk(status_o, "R8 set wins over read", int'(status_o), 1);
    endtask

    task automatic t_refresh_fixed;
        rev2_sel = 1'b0;
        wait_at(2, 21);
        chk(refresh_slot_o == 22, "R9 slot", int'(refresh_slot_o), 22);
        chk(!refresh_busy_o, "R9 idle before slot", int'(refresh_busy_o), 0);
        @(negedge clk);
        chk(refresh_busy_o, "R9 busy at slot", int'(refresh_busy_o), 1);
        wait_at(2, 27);
        chk(refresh_busy_o, "R9 busy last", int'(refresh_busy_o), 1);
        @(negedge clk);
        chk(!refresh_busy_o, "R9 idle after window", int'(refresh_busy_o), 0);
        wait_at(3, 0);
        chk(refresh_slot_o == 22, "R9 slot next line", int'(refresh_slot_o), 22);
    endtask

    task automatic t_refresh_alt;
        int s2, s3, s7, s8, s9, n, f;
        rev2_sel = 1'b1;
        wait_at(0, 0);
        if (field_o != 1) measure_frame(n, f);
        wait_at(2, 0); s2 = int'(refresh_slot_o);
        wait_at(3, 0); s3 = int'(refresh_slot_o);
        chk((s2 == 22 || s2 == 18) && (s3 == 22 || s3 == 18), "R10 slot values", s2, 22);
        chk(s2 != s3, "R10 alternates", s3, 40 - s2);
        wait_at(3, 18);
        chk(refresh_busy_o == (s3 == 18), "R10 busy follows slot", int'(refresh_busy_o),
            int'(s3 == 18));
        wait_at(7, 0); s7 = int'(refresh_slot_o);
        wait_at(8, 0); s8 = int'(refresh_slot_o);
        wait_at(9, 0); s9 = int'(refresh_slot_o);
        chk(s7 == s8, "R10 no flip into short line", s8, s7);
        chk(s8 != s9, "R10 flips after short line", s9, 40 - s8);
        rev2_sel = 1'b0;
    endtask

    initial begin
        t_reset;
        t_line;
        t_progressive;
        t_interlace;
        t_vblank;
        t_nmi;
        t_status;
        t_refresh_fixed;
        t_refresh_alt;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule